// File: doc/BRIEF.md
# SNR-Driven Soft Mute Attenuator

This block quiets a signed audio stream when reception gets weak. Each time a new signal-to-noise figure arrives (whole dB, with a strobe), it works out a target attenuation. The target grows in proportion to how far the SNR has dropped under a programmable threshold. It is capped at a programmable ceiling.

The applied attenuation does not jump to the target. It climbs toward it by a programmable attack step per SNR update and falls back by a programmable decay step. This gives a smooth fade instead of a click.

The current attenuation, in dB, picks a linear gain from a 64-entry table that is computed at elaboration. Every valid audio sample is multiplied by that gain, rounded and saturated, and presented one cycle later. A separate hard-mute input forces silence whatever the soft-mute state.

Typical settings are slope 2, ceiling 16 dB and threshold 4 dB for FM reception, and a threshold of 8 dB for AM and shortwave.

Top module: `soft_mute_atten`

## Requirements
- R1: When an SNR update has `snr_i >= snr_thr_i`, the target attenuation is 0 dB.
- R2: When `snr_i < snr_thr_i`, the target is `slope_i * (snr_thr_i - snr_i)` dB.
- R3: The target is clamped to `max_att_i`; with `max_att_i == 0` the target is always 0, so soft mute is disabled.
- R4: On an SNR update with the target above the current attenuation, `atten_o` rises by `attack_i` dB, but never past the target. It is visible the cycle after the strobe.
- R5: On an SNR update with the target below the current attenuation, `atten_o` falls by `decay_i` dB, but never below the target.
- R6: `atten_o` changes only on cycles where `snr_valid_i` is high; SNR values presented without the strobe are ignored.
- R7: While `hard_mute_i` is high, every output sample is 0.
- R8: A sample is scaled by the gain G(d) picked by the attenuation d = `atten_o` on the cycle it is accepted, and is presented with `aud_valid_o` one cycle later. G(d) = round(32768 * (58409/65536)^d), which is about 1 dB per step. The output is floor((x*G + 16384) / 32768), saturated to the signed range of `aud_o`.
- R9: At 0 dB attenuation and without hard mute, `aud_o` equals the accepted input bit for bit, including both signed extremes.
- R10: After reset, `atten_o` is 0, `aud_valid_o` is 0 and `aud_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snr_valid_i | input | 1 | Strobe for a new SNR value |
| snr_i | input | SNR_W | Measured SNR, whole dB, unsigned |
| snr_thr_i | input | SNR_W | SNR below which soft mute engages |
| slope_i | input | SLOPE_W | dB of attenuation per dB of shortfall |
| max_att_i | input | ATT_W | Attenuation ceiling in dB, 0 disables |
| attack_i | input | ATT_W | Largest rise per SNR update, dB |
| decay_i | input | ATT_W | Largest fall per SNR update, dB |
| hard_mute_i | input | 1 | Forces silent output |
| aud_valid_i | input | 1 | Input sample strobe |
| aud_i | input | DATA_W | Signed input sample |
| aud_valid_o | output | 1 | Output sample strobe |
| aud_o | output | DATA_W | Signed attenuated sample |
| atten_o | output | ATT_W | Current applied attenuation, dB |

## Verification
On every cycle, the assertions check three things. The target stays at zero when the SNR is not below the threshold and never exceeds the ceiling. Each update moves the attenuation only toward the target and by no more than one rate step, and it stays frozen without a strobe. Hard mute, the one-cycle output strobe and unity pass-through at 0 dB are checked too. Only the bench's scenarios can show the exact multi-update trajectory of attack and decay, and the rounded gain values of the whole table against an independently computed exponential. They also show clamping at large slopes, and full release back to bit-exact audio after a weak-signal episode.

// File: rtl/smute_pkg.sv
package smute_pkg;
  // fixed-point step of about -1 dB: 58409/65536
  localparam int unsigned STEP_NUM = 58409;

  function automatic int unsigned db_to_gain(input int unsigned db, input int unsigned frac);
    logic [63:0] acc;
    acc = 64'd1 << 47;
    for (int unsigned i = 0; i < db; i++) acc = (acc * 64'(STEP_NUM)) >> 16;
    acc = (acc + (64'd1 << (46 - frac))) >> (47 - frac);
    return int'(acc[31:0]);
  endfunction
endpackage

// File: rtl/smute_target.sv
module smute_target #(
  parameter int SNR_W   = 8,
  parameter int SLOPE_W = 4,
  parameter int ATT_W   = 6
) (
  input  logic [SNR_W-1:0]   snr_i,
  input  logic [SNR_W-1:0]   snr_thr_i,
  input  logic [SLOPE_W-1:0] slope_i,
  input  logic [ATT_W-1:0]   max_att_i,
  output logic [ATT_W-1:0]   tgt_o
);
  localparam int PROD_W = SNR_W + SLOPE_W;

  logic [SNR_W-1:0]  short_q;
  logic [PROD_W-1:0] prod;

  assign short_q = snr_thr_i - snr_i;
  assign prod    = PROD_W'(short_q) * PROD_W'(slope_i);

  always_comb begin
    if (max_att_i == '0 || snr_i >= snr_thr_i) tgt_o = '0;
    else if (prod > PROD_W'(max_att_i))        tgt_o = max_att_i;
    else                                       tgt_o = prod[ATT_W-1:0];
  end
endmodule

// File: rtl/smute_slew.sv
module smute_slew #(
  parameter int ATT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [ATT_W-1:0] tgt_i,
  input  logic [ATT_W-1:0] attack_i,
  input  logic [ATT_W-1:0] decay_i,
  output logic [ATT_W-1:0] cur_o
);
  logic [ATT_W-1:0] cur_q, cur_d;
  logic [ATT_W:0]   up_sum;
  logic [ATT_W-1:0] gap_dn;

  assign up_sum = {1'b0, cur_q} + {1'b0, attack_i};
  assign gap_dn = cur_q - tgt_i;

  always_comb begin
    cur_d = cur_q;
    if (upd_i) begin
      if (tgt_i > cur_q)
        cur_d = (up_sum >= {1'b0, tgt_i}) ? tgt_i : up_sum[ATT_W-1:0];
      else if (tgt_i < cur_q)
        cur_d = (gap_dn <= decay_i) ? tgt_i : cur_q - decay_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= cur_d;
  end

  assign cur_o = cur_q;

  p_attack_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && tgt_i > cur_q) |=>
      (cur_q >= $past(cur_q)) && (cur_q <= $past(tgt_i)) &&
      ({1'b0, cur_q} <= {1'b0, $past(cur_q)} + {1'b0, $past(attack_i)}));

  p_decay_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && tgt_i < cur_q) |=>
      (cur_q <= $past(cur_q)) && (cur_q >= $past(tgt_i)) &&
      ({1'b0, $past(cur_q)} <= {1'b0, cur_q} + {1'b0, $past(decay_i)}));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(cur_q));
endmodule

// File: rtl/smute_gain_lut.sv
module smute_gain_lut #(
  parameter int ATT_W  = 6,
  parameter int FRAC_W = 15,
  localparam int GAIN_W = FRAC_W + 1
) (
  input  logic [ATT_W-1:0]  att_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int DEPTH = 2 ** ATT_W;

  logic [GAIN_W-1:0] tbl [DEPTH];

  for (genvar d = 0; d < DEPTH; d++) begin : g_ent
    localparam int unsigned G = smute_pkg::db_to_gain(d, FRAC_W);
    assign tbl[d] = GAIN_W'(G);
  end

  assign gain_o = tbl[att_i];
endmodule

// File: rtl/smute_scaler.sv
module smute_scaler #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 15,
  localparam int GAIN_W = FRAC_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] aud_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic                     hard_mute_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] aud_o
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] RND   = PROD_W'(1) << (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] MAX_S = {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] MIN_S = {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [GAIN_W-1:0]        UNITY = GAIN_W'(1) << FRAC_W;

  logic signed [PROD_W-1:0] x_ext, g_ext, prod, shifted;
  logic signed [DATA_W-1:0] sat_d;

  assign x_ext   = {{(PROD_W-DATA_W){aud_i[DATA_W-1]}}, aud_i};
  assign g_ext   = {{(PROD_W-GAIN_W){1'b0}}, gain_i};
  assign prod    = x_ext * g_ext;
  assign shifted = (prod + RND) >>> FRAC_W;

  always_comb begin
    if      (shifted > MAX_S) sat_d = MAX_S[DATA_W-1:0];
    else if (shifted < MIN_S) sat_d = MIN_S[DATA_W-1:0];
    else                      sat_d = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      aud_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) aud_o <= hard_mute_i ? '0 : sat_d;
    end
  end

  p_hard_mute_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hard_mute_i) |=> (aud_o == '0));

  p_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_no_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_unity_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !hard_mute_i && gain_i == UNITY) |=> (aud_o == $past(aud_i)));
endmodule

// File: rtl/soft_mute_atten.sv
module soft_mute_atten #(
  parameter int DATA_W  = 16,
  parameter int SNR_W   = 8,
  parameter int SLOPE_W = 4,
  parameter int ATT_W   = 6,
  parameter int FRAC_W  = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     snr_valid_i,
  input  logic [SNR_W-1:0]         snr_i,
  input  logic [SNR_W-1:0]         snr_thr_i,
  input  logic [SLOPE_W-1:0]       slope_i,
  input  logic [ATT_W-1:0]         max_att_i,
  input  logic [ATT_W-1:0]         attack_i,
  input  logic [ATT_W-1:0]         decay_i,
  input  logic                     hard_mute_i,
  input  logic                     aud_valid_i,
  input  logic signed [DATA_W-1:0] aud_i,
  output logic                     aud_valid_o,
  output logic signed [DATA_W-1:0] aud_o,
  output logic [ATT_W-1:0]         atten_o
);
  localparam int GAIN_W = FRAC_W + 1;

  logic [ATT_W-1:0]  tgt;
  logic [ATT_W-1:0]  cur;
  logic [GAIN_W-1:0] gain;

  smute_target #(.SNR_W(SNR_W), .SLOPE_W(SLOPE_W), .ATT_W(ATT_W)) u_target (
    .snr_i     (snr_i),
    .snr_thr_i (snr_thr_i),
    .slope_i   (slope_i),
    .max_att_i (max_att_i),
    .tgt_o     (tgt)
  );

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snr_i >= snr_thr_i) |-> (tgt == '0));

  p_ceiling_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt <= max_att_i);

  p_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_att_i == '0) |-> (tgt == '0));

  smute_slew #(.ATT_W(ATT_W)) u_slew (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (snr_valid_i),
    .tgt_i    (tgt),
    .attack_i (attack_i),
    .decay_i  (decay_i),
    .cur_o    (cur)
  );

  smute_gain_lut #(.ATT_W(ATT_W), .FRAC_W(FRAC_W)) u_lut (
    .att_i  (cur),
    .gain_o (gain)
  );

  smute_scaler #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_scaler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (aud_valid_i),
    .aud_i       (aud_i),
    .gain_i      (gain),
    .hard_mute_i (hard_mute_i),
    .valid_o     (aud_valid_o),
    .aud_o       (aud_o)
  );

  assign atten_o = cur;
endmodule

// File: tb/soft_mute_atten_tb_top.sv
`timescale 1ns/1ps
module soft_mute_atten_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snr_v = 1'b0;
  logic [7:0]  snr = '0, thr = 8'd4;
  logic [3:0]  slope = 4'd2;
  logic [5:0]  mx = 6'd16, atk = 6'd3, dec = 6'd1;
  logic        hm = 1'b0;
  logic        av = 1'b0;
  logic signed [15:0] ain = '0;
  logic        ov;
  logic signed [15:0] aout;
  logic [5:0]  att;

  int n_chk = 0, n_bad = 0;
  int m_att = 0;

  always #4 clk = ~clk;

  soft_mute_atten dut_i (
    .clk_i(clk), .rst_ni(rst_n), .snr_valid_i(snr_v), .snr_i(snr),
    .snr_thr_i(thr), .slope_i(slope), .max_att_i(mx), .attack_i(atk),
    .decay_i(dec), .hard_mute_i(hm), .aud_valid_i(av), .aud_i(ain),
    .aud_valid_o(ov), .aud_o(aout), .atten_o(att)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tgt_f(input int s);
    int p;
    if (int'(mx) == 0 || s >= int'(thr)) return 0;
    p = int'(slope) * (int'(thr) - s);
    return (p > int'(mx)) ? int'(mx) : p;
  endfunction

  function automatic int gain_f(input int d);
    real g;
    g = 32768.0 * ((58409.0 / 65536.0) ** real'(d));
    return $rtoi(g + 0.5);
  endfunction

  function automatic int out_f(input int x);
    longint r;
    if (hm) return 0;
    r = (longint'(x) * longint'(gain_f(m_att)) + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic snr_upd(input int s, input string req);
    int t;
    @(negedge clk);
    snr = 8'(s); snr_v = 1'b1;
    t = tgt_f(s);
    if (t > m_att) m_att = (m_att + int'(atk) >= t) ? t : m_att + int'(atk);
    else if (t < m_att) m_att = (m_att - t <= int'(dec)) ? t : m_att - int'(dec);
    @(negedge clk);
    snr_v = 1'b0;
    check(req, att, m_att);
  endtask

  task automatic sample(input int x, input string req);
    int e;
    @(negedge clk);
    ain = 16'(x); av = 1'b1;
    e = out_f(x);
    @(negedge clk);
    av = 1'b0;
    check({req, " valid"}, ov, 1);
    check(req, aout, e);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 atten", att, 0);
    check("R10 valid", ov, 0);
    check("R10 data", aout, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 pass-through extremes at 0 dB
    sample(-32768, "R9 min");
    sample(32767, "R9 max");
    sample(1234, "R9 mid");

    // R1 at threshold, above
    snr_upd(4, "R1 at thr");
    snr_upd(30, "R1 above");

    // R2/R4 attack 0,3,6,8 with target 8
    snr_upd(0, "R4 step1");
    check("R4 first rise", att, 3);
    snr_upd(0, "R4 step2");
    snr_upd(0, "R4 reach");
    check("R2 target 8", att, 8);
    sample(-20000, "R8 at 8dB");

    // R6 SNR without strobe ignored
    @(negedge clk); snr = 8'd200;
    repeat (4) @(negedge clk);
    check("R6 no strobe", att, 8);

    // R5 decay one step per update
    snr_upd(10, "R5 fall1");
    check("R5 fall by 1", att, 7);
    repeat (7) snr_upd(10, "R5 fall");
    check("R5 released", att, 0);
    sample(-7777, "R9 after release");

    // R3 clamp
    thr = 8'd40; slope = 4'd15; mx = 6'd16; atk = 6'd63;
    snr_upd(0, "R3 clamp");
    check("R3 clamp value", att, 16);
    sample(32767, "R8 at 16dB");

    // R3 max 0 disables
    mx = 6'd0; dec = 6'd63;
    snr_upd(0, "R3 disabled");
    check("R3 off value", att, 0);

    // R7 hard mute
    hm = 1'b1;
    sample(-32768, "R7 mute");
    sample(555, "R7 mute");
    hm = 1'b0;

    // R8 full table sweep
    thr = 8'd63; slope = 4'd1; mx = 6'd63; atk = 6'd1; dec = 6'd1;
    for (int d = 1; d <= 63; d++) begin
      snr_upd(63 - d, "R4 sweep");
      sample(32767, "R8 sweep");
      sample(-32768, "R8 sweep neg");
    end

    // mixed random
    for (int i = 0; i < 1500; i++) begin
      int k;
      k = int'($urandom_range(9));
      if (k == 0) begin
        @(negedge clk);
        thr = 8'($urandom_range(60)); slope = 4'($urandom_range(15));
        mx = 6'($urandom_range(63)); atk = 6'($urandom_range(20));
        dec = 6'($urandom_range(20)); hm = ($urandom_range(7) == 0);
      end else if (k < 5) begin
        snr_upd(int'($urandom_range(80)), "R2 rand");
      end else begin
        sample(int'($urandom_range(65535)) - 32768, "R8 rand");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule